// File: doc/BRIEF.md
# Serial configuration write port

This block receives configuration writes over a receive-only SPI link (serial clock, data in, active-low select) and keeps five configuration registers for a pseudo-random sequence generator: a clock-divide select, a sequence repeat count, a data bit count, a length-enable mask and a feedback tap mask. All three serial inputs are brought into the system clock domain through two-flop synchronisers. Serial clock edges are then detected with system clock logic, so the link must run well below the system clock rate.

Each select-low session carries a command byte and then a data byte. If the command is a legal write, the data byte lands in the addressed register and stays there until it is overwritten or reset. A debug input forces a fixed preset onto the outputs. While it is high, the stored registers cannot be written. When it drops, the stored values appear again.

Top module: `cfgw_port`

## Requirements
- R1: A low `rst_n` sampled on a rising clock edge clears all five stored registers to zero.
- R2: The link is SPI mode 0. A bit is taken on each rising serial clock edge while select is low, and the first bit of a byte is its most significant bit.
- R3: The first byte of a session is the command. If its bit 7 is 1 and its bits 2:0 hold address 1, 2, 3, 4 or 5, the second byte is stored into, in that order, the divider select, repeat count, data bit count, length mask or tap mask, and held there.
- R4: A command with bit 7 equal to 0, or with address 0, 6 or 7, writes nothing.
- R5: Bits 6:3 of the command byte have no effect.
- R6: At most one register is written per select-low session. Any third or later byte is ignored.
- R7: Raising select discards the command and any partial byte. The next session starts again with a command byte.
- R8: The divider select output is 3 bits wide and takes bits 2:0 of its data byte (division by 2 to that power).
- R9: While `debug_i` is high, the outputs show divider 4 (/16), repeat 7, bit count 7, length mask 0x0F and tap mask 0x0C, and writes are dropped. Once it is low, the stored values show again.
- R10: Take clock edge A as the first rising system clock edge that samples the last serial clock rise of a data byte high. The written register output changes at edge A+2 and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sck_i | input | 1 | Serial clock, asynchronous |
| mosi_i | input | 1 | Serial data in, asynchronous |
| csn_i | input | 1 | Active-low select, asynchronous |
| debug_i | input | 1 | Preset force and write lock, synchronous to clk |
| div_sel_o | output | 3 | Clock divide select |
| rep_cnt_o | output | 8 | Sequence repeat count |
| bit_cnt_o | output | 8 | Data bit count |
| len_mask_o | output | 8 | Length-enable mask |
| tap_mask_o | output | 8 | Feedback tap mask |

## Verification
Two things can happen in the same clock cycle: the byte-complete strobe that would commit a write, and either a select release or a debug level that must cancel it. The bench drives these overlaps as follows: a full write while debug is high, a select release partway through a byte, and sessions with three or four bytes. A behavioural model steps through the synchronised input history and is compared with every output on every clock. Directed checks then compare the final register values with literal constants, and a separate check confirms the exact edge at which a write becomes visible.

// File: rtl/cfgw_pkg.sv
// Shared widths, register addresses, debug presets and types for the
// serial configuration write port.
package cfgw_pkg;
    localparam int REG_W         = 8;
    localparam int DIV_W         = 3;
    localparam int ADDR_W        = 3;
    localparam int BITS_PER_BYTE = 8;
    localparam int CNT_W         = $clog2(BITS_PER_BYTE);

    localparam logic [ADDR_W-1:0] A_DIV  = 3'd1;
    localparam logic [ADDR_W-1:0] A_REP  = 3'd2;
    localparam logic [ADDR_W-1:0] A_BITS = 3'd3;
    localparam logic [ADDR_W-1:0] A_LEN  = 3'd4;
    localparam logic [ADDR_W-1:0] A_TAP  = 3'd5;

    typedef struct packed {
        logic [DIV_W-1:0] div;
        logic [REG_W-1:0] rep;
        logic [REG_W-1:0] nbits;
        logic [REG_W-1:0] len;
        logic [REG_W-1:0] tap;
    } cfg_bank_t;

    localparam cfg_bank_t CFG_DEBUG = '{div: 3'd4, rep: 8'd7, nbits: 8'd7,
                                        len: 8'h0F, tap: 8'h0C};

    typedef enum logic [1:0] {ST_CMD, ST_DATA, ST_DONE} rx_stage_e;
endpackage

// File: rtl/cfgw_sync.sv
// Multi-stage flop synchroniser, one chain per bit.
// Assumes each input bit is independent; the reset value is set per bit.
module cfgw_sync #(
    parameter int              WIDTH   = 1,
    parameter int              STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] chain [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            // First stage captures the asynchronous input.
            always_ff @(posedge clk) begin
                if (!rst_n) chain[0] <= RST_VAL;
                else        chain[0] <= d;
            end
        end else begin : g_next
            // Later stages let a metastable value settle.
            always_ff @(posedge clk) begin
                if (!rst_n) chain[s] <= RST_VAL;
                else        chain[s] <= chain[s-1];
            end
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/cfgw_rx.sv
// Serial byte receiver: detects serial clock rises in the system clock
// domain and shifts data in MSB first while select is low.
// Assumes synchronised inputs and a serial clock well below clk / 4.
module cfgw_rx
    import cfgw_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sck_s,
    input  logic             mosi_s,
    input  logic             csn_s,
    output logic             byte_stb,
    output logic [REG_W-1:0] byte_val,
    output logic [CNT_W-1:0] bit_cnt
);
    logic             sck_q;
    logic [REG_W-2:0] shreg;
    logic             rise;

    assign rise     = sck_s & ~sck_q;
    assign byte_stb = rise & ~csn_s & (bit_cnt == CNT_W'(BITS_PER_BYTE - 1));
    assign byte_val = {shreg, mosi_s};

    // Keep the previous serial clock level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) sck_q <= 1'b0;
        else        sck_q <= sck_s;
    end

    // Shift a bit in on each rise; a released select clears the partial byte.
    always_ff @(posedge clk) begin
        if (!rst_n || csn_s) begin
            shreg   <= '0;
            bit_cnt <= '0;
        end else if (rise) begin
            shreg   <= {shreg[REG_W-3:0], mosi_s};
            bit_cnt <= bit_cnt + 1'b1;
        end
    end
endmodule

// File: rtl/cfgw_bank.sv
// Command decoder and register bank. The first byte of a session is kept
// as the command, the second byte is written if the command is legal,
// and later bytes are ignored. Debug forces presets and drops writes.
// Assumes debug_i is synchronous to clk.
module cfgw_bank
    import cfgw_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              csn_s,
    input  logic              byte_stb,
    input  logic [REG_W-1:0]  byte_val,
    input  logic              debug_i,
    output cfg_bank_t         cfg_o,
    output cfg_bank_t         stored_o,
    output logic              wr_en_o,
    output logic [ADDR_W-1:0] wr_addr_o,
    output logic              stage_cmd_o
);
    rx_stage_e         stage;
    logic              cmd_wr;
    logic [ADDR_W-1:0] cmd_addr;
    logic              addr_ok;

    assign addr_ok     = (cmd_addr >= A_DIV) && (cmd_addr <= A_TAP);
    assign wr_en_o     = byte_stb && (stage == ST_DATA) && cmd_wr && addr_ok && !debug_i;
    assign wr_addr_o   = cmd_addr;
    assign stage_cmd_o = (stage == ST_CMD);

    // Track which byte of the session is arriving and hold the command.
    always_ff @(posedge clk) begin
        if (!rst_n || csn_s) begin
            stage    <= ST_CMD;
            cmd_wr   <= 1'b0;
            cmd_addr <= '0;
        end else if (byte_stb) begin
            case (stage)
                ST_CMD: begin
                    cmd_wr   <= byte_val[REG_W-1];
                    cmd_addr <= byte_val[ADDR_W-1:0];
                    stage    <= ST_DATA;
                end
                default: stage <= ST_DONE;
            endcase
        end
    end

    // Store the data byte into the addressed register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stored_o <= '0;
        end else if (wr_en_o) begin
            case (cmd_addr)
                A_DIV:   stored_o.div   <= byte_val[DIV_W-1:0];
                A_REP:   stored_o.rep   <= byte_val;
                A_BITS:  stored_o.nbits <= byte_val;
                A_LEN:   stored_o.len   <= byte_val;
                default: stored_o.tap   <= byte_val;
            endcase
        end
    end

    // Select the preset set while debug is high.
    always_comb begin
        cfg_o = debug_i ? CFG_DEBUG : stored_o;
    end
endmodule

// File: rtl/cfgw_port.sv
// Top of the serial configuration write port: synchronisers, byte
// receiver and register bank, with the registers on parallel outputs.
// Assumes clk is at least four times the serial clock rate.
module cfgw_port
    import cfgw_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sck_i,
    input  logic             mosi_i,
    input  logic             csn_i,
    input  logic             debug_i,
    output logic [DIV_W-1:0] div_sel_o,
    output logic [REG_W-1:0] rep_cnt_o,
    output logic [REG_W-1:0] bit_cnt_o,
    output logic [REG_W-1:0] len_mask_o,
    output logic [REG_W-1:0] tap_mask_o
);
    logic              csn_s, sck_s, mosi_s;
    logic              byte_stb;
    logic [REG_W-1:0]  byte_val;
    logic [CNT_W-1:0]  rx_cnt;
    cfg_bank_t         cfg, stored;
    logic              wr_en;
    logic [ADDR_W-1:0] wr_addr;
    logic              stage_cmd;

    cfgw_sync #(.WIDTH(3), .STAGES(2), .RST_VAL(3'b100)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({csn_i, sck_i, mosi_i}),
        .q     ({csn_s, sck_s, mosi_s})
    );

    cfgw_rx u_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .sck_s    (sck_s),
        .mosi_s   (mosi_s),
        .csn_s    (csn_s),
        .byte_stb (byte_stb),
        .byte_val (byte_val),
        .bit_cnt  (rx_cnt)
    );

    cfgw_bank u_bank (
        .clk         (clk),
        .rst_n       (rst_n),
        .csn_s       (csn_s),
        .byte_stb    (byte_stb),
        .byte_val    (byte_val),
        .debug_i     (debug_i),
        .cfg_o       (cfg),
        .stored_o    (stored),
        .wr_en_o     (wr_en),
        .wr_addr_o   (wr_addr),
        .stage_cmd_o (stage_cmd)
    );

    assign div_sel_o  = cfg.div;
    assign rep_cnt_o  = cfg.rep;
    assign bit_cnt_o  = cfg.nbits;
    assign len_mask_o = cfg.len;
    assign tap_mask_o = cfg.tap;
endmodule

// File: rtl/cfgw_checker.sv
// Property checker for cfgw_port, attached by bind. It watches the write
// strobe, stored registers and receiver state against the session rules.
module cfgw_checker
    import cfgw_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              debug_i,
    input logic              csn_s,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [CNT_W-1:0]  rx_cnt,
    input logic              stage_cmd,
    input cfg_bank_t         stored
);
    logic wrote_in_session;

    // Remember whether this session has already committed a write.
    always_ff @(posedge clk) begin
        if (!rst_n || csn_s) wrote_in_session <= 1'b0;
        else if (wr_en)      wrote_in_session <= 1'b1;
    end

    AST_RESET_CLEARS: assert property (@(posedge clk)
        !rst_n |=> (stored == '0)); // R1

    AST_CHANGE_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$stable(stored)) |-> $past(wr_en)); // R3

    AST_LEGAL_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (wr_addr >= A_DIV && wr_addr <= A_TAP)); // R4

    AST_ONE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> !wrote_in_session); // R6

    AST_CS_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        csn_s |=> (rx_cnt == '0 && stage_cmd)); // R7

    AST_DEBUG_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        debug_i |=> $stable(stored)); // R9
endmodule

bind cfgw_port cfgw_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .debug_i   (debug_i),
    .csn_s     (csn_s),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .rx_cnt    (rx_cnt),
    .stage_cmd (stage_cmd),
    .stored    (stored)
);

// File: tb/cfgw_port_tb.sv
module cfgw_port_tb;
    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sck = 1'b0, mosi = 1'b0, csn = 1'b1, dbg = 1'b0;
    logic [2:0] div_sel;
    logic [7:0] rep_cnt, bit_cnt, len_mask, tap_mask;

    int n_chk = 0, n_fail = 0;
    bit started = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cfgw_port u_dut (
        .clk(clk), .rst_n(rst_n), .sck_i(sck), .mosi_i(mosi), .csn_i(csn),
        .debug_i(dbg), .div_sel_o(div_sel), .rep_cnt_o(rep_cnt),
        .bit_cnt_o(bit_cnt), .len_mask_o(len_mask), .tap_mask_o(tap_mask)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // ---- behavioural reference model ----
    int m_reg[1:5];
    int m_cnt, m_stage, m_cmd, m_sh;
    int h_sck[1:3], h_mosi[1:3], h_csn[1:3];

    always @(posedge clk) begin
        if (!rst_n) begin
            foreach (m_reg[i]) m_reg[i] = 0;
            m_cnt = 0; m_stage = 0; m_cmd = 0; m_sh = 0;
            for (int i = 1; i <= 3; i++) begin h_sck[i] = 0; h_mosi[i] = 0; h_csn[i] = 1; end
        end else begin
            if (h_csn[2] != 0) begin
                m_cnt = 0; m_stage = 0; m_cmd = 0; m_sh = 0;
            end else if (h_sck[2] == 1 && h_sck[3] == 0) begin
                m_sh = ((m_sh << 1) | h_mosi[2]) & 255;
                if (m_cnt == 7) begin
                    if (m_stage == 0) begin
                        m_cmd = m_sh; m_stage = 1;
                    end else if (m_stage == 1) begin
                        if ((m_cmd & 128) != 0 && (m_cmd % 8) >= 1 && (m_cmd % 8) <= 5 && !dbg)
                            m_reg[m_cmd % 8] = ((m_cmd % 8) == 1) ? (m_sh % 8) : m_sh;
                        m_stage = 2;
                    end
                    m_sh = 0;
                end
                m_cnt = (m_cnt + 1) % 8;
            end
            for (int i = 3; i >= 2; i--) begin
                h_sck[i] = h_sck[i-1]; h_mosi[i] = h_mosi[i-1]; h_csn[i] = h_csn[i-1];
            end
            h_sck[1] = sck; h_mosi[1] = mosi; h_csn[1] = csn;
        end
        started = 1'b1;
    end

    // Per-clock comparison against the model (R10 timing, R9 presets).
    always @(negedge clk) begin
        if (started) begin
            int e1, e2, e3, e4, e5;
            e1 = dbg ? 4 : m_reg[1];  e2 = dbg ? 7 : m_reg[2];
            e3 = dbg ? 7 : m_reg[3];  e4 = dbg ? 15 : m_reg[4];
            e5 = dbg ? 12 : m_reg[5];
            check(div_sel == e1, "R10 div", div_sel, e1);
            check(rep_cnt == e2, "R10 rep", rep_cnt, e2);
            check(bit_cnt == e3, "R10 bits", bit_cnt, e3);
            check(len_mask == e4, "R10 len", len_mask, e4);
            check(tap_mask == e5, "R10 tap", tap_mask, e5);
        end
    end

    // ---- stimulus ----
    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_bit(input logic b);
        mosi = b; wait_clk(HALF); sck = 1'b1; wait_clk(HALF); sck = 1'b0;
    endtask

    task automatic send_byte(input logic [7:0] b);
        for (int i = 7; i >= 0; i--) send_bit(b[i]);
    endtask

    task automatic session(input logic [7:0] b0, b1, b2, b3, input int n);
        csn = 1'b0; wait_clk(HALF);
        send_byte(b0);
        if (n > 1) send_byte(b1);
        if (n > 2) send_byte(b2);
        if (n > 3) send_byte(b3);
        wait_clk(HALF); csn = 1'b1; wait_clk(8);
    endtask

    task automatic wr(input logic [7:0] c, d);
        session(c, d, 8'h00, 8'h00, 2);
    endtask

    initial begin
        wait_clk(4); rst_n = 1'b1; wait_clk(2);
        check(div_sel == 0 && rep_cnt == 0 && bit_cnt == 0 && len_mask == 0 && tap_mask == 0,
              "R1 reset", {div_sel, rep_cnt, bit_cnt}, 0);

        wr(8'h82, 8'h1E);  check(rep_cnt == 8'h1E, "R2 msb-first", rep_cnt, 8'h1E);
        wr(8'h83, 8'h81);  check(bit_cnt == 8'h81, "R3 bits", bit_cnt, 8'h81);
        wr(8'h84, 8'h3F);  check(len_mask == 8'h3F, "R3 len", len_mask, 8'h3F);
        wr(8'h85, 8'h2D);  check(tap_mask == 8'h2D, "R3 tap", tap_mask, 8'h2D);
        wr(8'h81, 8'hFF);  check(div_sel == 3'd7, "R8 div", div_sel, 7);

        wr(8'h7B, 8'h55);  check(bit_cnt == 8'h81, "R4 bit7 clear", bit_cnt, 8'h81);
        wr(8'h80, 8'h12);  wr(8'h86, 8'h34);  wr(8'h87, 8'h56);
        check(div_sel == 7 && rep_cnt == 8'h1E && bit_cnt == 8'h81 && len_mask == 8'h3F
              && tap_mask == 8'h2D, "R4 bad addr", {rep_cnt, bit_cnt}, 16'h1E81);

        wr(8'hFC, 8'h07);  check(len_mask == 8'h07, "R5 ignored bits", len_mask, 8'h07);

        session(8'h83, 8'h11, 8'h22, 8'h00, 3);
        check(bit_cnt == 8'h11, "R6 third byte", bit_cnt, 8'h11);
        session(8'h85, 8'h44, 8'h82, 8'h66, 4);
        check(tap_mask == 8'h44, "R6 tap", tap_mask, 8'h44);
        check(rep_cnt == 8'h1E, "R6 second write", rep_cnt, 8'h1E);

        csn = 1'b0; wait_clk(HALF);
        send_bit(1'b1); send_bit(1'b0); send_bit(1'b0); send_bit(1'b0);
        wait_clk(HALF); csn = 1'b1; wait_clk(8);
        wr(8'h82, 8'h5A);  check(rep_cnt == 8'h5A, "R7 partial discarded", rep_cnt, 8'h5A);
        session(8'h83, 8'h00, 8'h00, 8'h00, 1);
        session(8'h99, 8'h00, 8'h00, 8'h00, 1);
        check(bit_cnt == 8'h11, "R7 command reset", bit_cnt, 8'h11);
        check(div_sel == 3'd7, "R7 lone command", div_sel, 7);

        dbg = 1'b1; wait_clk(2);
        check(div_sel == 4 && rep_cnt == 7 && bit_cnt == 7 && len_mask == 8'h0F
              && tap_mask == 8'h0C, "R9 presets", {div_sel, rep_cnt}, 12'h407);
        wr(8'h82, 8'h99);
        check(rep_cnt == 8'd7, "R9 forced", rep_cnt, 7);
        dbg = 1'b0; wait_clk(2);
        check(rep_cnt == 8'h5A, "R9 write dropped", rep_cnt, 8'h5A);

        // R10: exact visibility edge of a write
        csn = 1'b0; wait_clk(HALF);
        send_byte(8'h83);
        for (int i = 7; i >= 1; i--) send_bit(8'h6B >> i);
        mosi = 1'b1; wait_clk(HALF); sck = 1'b1;
        @(posedge clk); @(posedge clk); @(negedge clk);
        check(bit_cnt == 8'h11, "R10 not early", bit_cnt, 8'h11);
        @(posedge clk); @(negedge clk);
        check(bit_cnt == 8'h6B, "R10 on time", bit_cnt, 8'h6B);
        wait_clk(HALF); sck = 1'b0; wait_clk(HALF); csn = 1'b1; wait_clk(8);

        rst_n = 1'b0; wait_clk(2); rst_n = 1'b1; wait_clk(1);
        check(div_sel == 0 && rep_cnt == 0 && bit_cnt == 0 && len_mask == 0 && tap_mask == 0,
              "R1 reset again", bit_cnt, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule